// File: doc/BRIEF.md
# Fractional Clock Rate Controller

This block turns a parent clock into a clock-enable stream that lets through a chosen share of the parent cycles. Each frame of 32 parent cycles carries between 1 and 32 enable pulses. The count is 32 minus a 5-bit rate code, so the effective rate is parent × (32 − code) / 32. Downstream logic qualifies its flops with the enable, which removes pulses without any clock gating.

Software uses two registers. The frequency control register holds a pending rate code, and writing it alone changes nothing at the output. The commit register holds a single busy flag. Writing 1 to that flag arms a change, and the controller copies the pending code into the active code at the next frame boundary. The flag then clears by itself, so software polls it to learn when the new rate is in force. The pulses inside a frame are spread evenly by an accumulator, so the gaps between them differ by at most one cycle.

Top module: `frac_rate_ctl`

## Requirements
- R1: After a synchronous reset, the frequency register (offset 0x0E0) and the commit register (offset 0x004) both read 0, and the enable is high on all 32 cycles of every frame.
- R2: A write to offset 0x0E0 stores wdata bits 12:8 as the pending code. A read returns that code in bits 12:8 and 0 in every other bit. The output rate does not change until a commit is serviced.
- R3: A write to offset 0x004 with bit 31 set, while the controller is idle, makes bit 31 of that register read 1 from the next cycle on.
- R4: Once a commit is armed, the pending code becomes active at the edge that ends frame position 31. The frame that follows carries 32 − code pulses, and this code is the pending value at that edge.
- R5: The busy bit reads 1 up to and including the first cycle in which the new code is active, and reads 0 from the cycle after.
- R6: A commit write while busy has no effect, and a write of 0 to bit 31 never changes the busy bit. A change to the pending code without a new commit leaves the rate as it was.
- R7: Each 32-cycle frame carries exactly 32 − code enable pulses: code 0 gives 32 pulses and code 31 gives 1.
- R8: Let k be the frame position (0 to 31) and m = 32 − code. The enable is high at position k exactly when floor((k+1)·m/32) > floor(k·m/32).
- R9: The busy bit clears no more than 34 cycles after the commit write.
- R10: A write to any other offset changes no state, and a read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid while bus_sel is high with bus_wr low |
| clk_en_o | output | 1 | Pulse-swallowing clock enable |

## Verification
The hardest case to reach is a register access that lands while a commit is waiting for its frame boundary. Examples are a second commit, a commit write of 0, or a new pending code written between the commit and the boundary. These change the outcome only if they arrive inside that window. The stimulus issues them on the cycles right after the commit write, so they always fall while the controller is armed. The bench then polls the busy bit on every cycle, and a reference model compares the busy bit and every enable pulse against the expected values.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    localparam int FCR_AW     = 12;
    localparam int FCR_DW     = 32;
    localparam int FCR_CODE_W = 5;

    typedef enum logic [1:0] {
        CM_IDLE   = 2'd0,
        CM_ARMED  = 2'd1,
        CM_SETTLE = 2'd2
    } commit_state_e;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [FCR_AW-1:0] addr;
        logic [FCR_DW-1:0] wdata;
    } fcr_bus_t;

    function automatic logic addr_hit(input fcr_bus_t b, input logic [FCR_AW-1:0] ofs);
        return b.sel && (b.addr == ofs);
    endfunction

endpackage

// File: rtl/fcr_regs.sv
module fcr_regs
    import fcr_pkg::*;
#(
    parameter int                CODE_W   = FCR_CODE_W,
    parameter logic [FCR_AW-1:0] FREQ_OFS = 12'h0E0,
    parameter logic [FCR_AW-1:0] KICK_OFS = 12'h004,
    parameter int                CODE_LSB = 8,
    parameter int                KICK_BIT = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  fcr_bus_t          bus,
    input  logic              busy,
    output logic [CODE_W-1:0] pending_code,
    output logic              kick_req,
    output logic [FCR_DW-1:0] rdata
);

    logic freq_wr;

    assign freq_wr  = addr_hit(bus, FREQ_OFS) && bus.wr;
    assign kick_req = addr_hit(bus, KICK_OFS) && bus.wr && bus.wdata[KICK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_code <= '0;
        end else if (freq_wr) begin
            pending_code <= bus.wdata[CODE_LSB +: CODE_W];
        end
    end

    always_comb begin
        rdata = '0;
        if (bus.sel && !bus.wr) begin
            if (bus.addr == FREQ_OFS) begin
                rdata[CODE_LSB +: CODE_W] = pending_code;
            end else if (bus.addr == KICK_OFS) begin
                rdata[KICK_BIT] = busy;
            end
        end
    end

endmodule

// File: rtl/fcr_commit.sv
module fcr_commit
    import fcr_pkg::*;
#(
    parameter int CODE_W = FCR_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kick_req,
    input  logic              frame_last,
    input  logic [CODE_W-1:0] pending_code,
    output logic [CODE_W-1:0] active_code,
    output logic              busy
);

    commit_state_e state_q;

    assign busy = (state_q != CM_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= CM_IDLE;
            active_code <= '0;
        end else begin
            case (state_q)
                CM_IDLE: begin
                    if (kick_req) begin
                        state_q <= CM_ARMED;
                    end
                end
                CM_ARMED: begin
                    if (frame_last) begin
                        active_code <= pending_code;
                        state_q     <= CM_SETTLE;
                    end
                end
                CM_SETTLE: begin
                    state_q <= CM_IDLE;
                end
                default: begin
                    state_q <= CM_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/fcr_pulse.sv
module fcr_pulse
    import fcr_pkg::*;
#(
    parameter int CODE_W = FCR_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] active_code,
    output logic              clk_en,
    output logic              frame_last
);

    localparam int FRAME = 1 << CODE_W;
    localparam int MW    = CODE_W + 1;

    logic [CODE_W-1:0] pos_q;
    logic [CODE_W-1:0] acc_q;
    logic [MW-1:0]     mult;
    logic [MW-1:0]     sum;

    assign mult       = MW'(FRAME) - {1'b0, active_code};
    assign sum        = {1'b0, acc_q} + mult;
    assign clk_en     = sum[CODE_W];
    assign frame_last = &pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            acc_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
            acc_q <= sum[CODE_W-1:0];
        end
    end

endmodule

// File: rtl/frac_rate_ctl.sv
module frac_rate_ctl
    import fcr_pkg::*;
#(
    parameter int                CODE_W   = FCR_CODE_W,
    parameter logic [FCR_AW-1:0] FREQ_OFS = 12'h0E0,
    parameter logic [FCR_AW-1:0] KICK_OFS = 12'h004,
    parameter int                CODE_LSB = 8,
    parameter int                KICK_BIT = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [FCR_AW-1:0] bus_addr,
    input  logic [FCR_DW-1:0] bus_wdata,
    output logic [FCR_DW-1:0] bus_rdata,
    output logic              clk_en_o
);

    fcr_bus_t          bus;
    logic [CODE_W-1:0] pending_code;
    logic [CODE_W-1:0] active_code;
    logic              kick_req;
    logic              kick_busy;
    logic              frame_last;

    assign bus = '{sel: bus_sel, wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

    fcr_regs #(
        .CODE_W  (CODE_W),
        .FREQ_OFS(FREQ_OFS),
        .KICK_OFS(KICK_OFS),
        .CODE_LSB(CODE_LSB),
        .KICK_BIT(KICK_BIT)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus         (bus),
        .busy        (kick_busy),
        .pending_code(pending_code),
        .kick_req    (kick_req),
        .rdata       (bus_rdata)
    );

    fcr_commit #(.CODE_W(CODE_W)) u_commit (
        .clk         (clk),
        .rst         (rst),
        .kick_req    (kick_req),
        .frame_last  (frame_last),
        .pending_code(pending_code),
        .active_code (active_code),
        .busy        (kick_busy)
    );

    fcr_pulse #(.CODE_W(CODE_W)) u_pulse (
        .clk        (clk),
        .rst        (rst),
        .active_code(active_code),
        .clk_en     (clk_en_o),
        .frame_last (frame_last)
    );

endmodule

// File: rtl/frac_rate_ctl_checker.sv
module frac_rate_ctl_checker
    import fcr_pkg::*;
#(
    parameter int                CODE_W   = FCR_CODE_W,
    parameter logic [FCR_AW-1:0] FREQ_OFS = 12'h0E0,
    parameter logic [FCR_AW-1:0] KICK_OFS = 12'h004,
    parameter int                KICK_BIT = 31
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [FCR_AW-1:0] bus_addr,
    input logic [FCR_DW-1:0] bus_wdata,
    input logic              clk_en_o,
    input logic              busy,
    input logic              frame_last,
    input logic [CODE_W-1:0] active_code,
    input logic [CODE_W-1:0] pending_code
);

    localparam int FRAME = 1 << CODE_W;
    localparam int CW1   = CODE_W + 1;
    localparam int BW    = CODE_W + 2;

    logic [CW1-1:0] pulse_cnt;
    logic [BW-1:0]  busy_cnt;
    logic           kick_one;
    logic           kick_zero;
    logic           freq_write;

    assign kick_one   = bus_sel && bus_wr && (bus_addr == KICK_OFS) && bus_wdata[KICK_BIT];
    assign kick_zero  = bus_sel && bus_wr && (bus_addr == KICK_OFS) && !bus_wdata[KICK_BIT];
    assign freq_write = bus_sel && bus_wr && (bus_addr == FREQ_OFS);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_cnt <= '0;
            busy_cnt  <= '0;
        end else begin
            pulse_cnt <= frame_last ? '0 : pulse_cnt + CW1'(clk_en_o);
            busy_cnt  <= busy ? busy_cnt + 1'b1 : '0;
        end
    end

    AST_PULSES_PER_FRAME: assert property (@(posedge clk) disable iff (rst)
        frame_last |-> ((pulse_cnt + CW1'(clk_en_o)) == (CW1'(FRAME) - CW1'(active_code)))); // R7

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
        (active_code == '0) |-> clk_en_o); // R7

    AST_PENDING_HOLD: assert property (@(posedge clk) disable iff (rst)
        !freq_write |=> $stable(pending_code)); // R2

    AST_ACTIVE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        !frame_last |=> $stable(active_code)); // R4

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(active_code)); // R6

    AST_KICK_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (kick_one && !busy) |=> busy); // R3

    AST_ZERO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (kick_zero && !busy) |=> !busy); // R6

    AST_CLEAR_AFTER_APPLY: assert property (@(posedge clk) disable iff (rst)
        (busy && frame_last) |=> (busy ##1 !busy)); // R5

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt < BW'(FRAME + 2))); // R9

endmodule

bind frac_rate_ctl frac_rate_ctl_checker #(
    .CODE_W  (CODE_W),
    .FREQ_OFS(FREQ_OFS),
    .KICK_OFS(KICK_OFS),
    .KICK_BIT(KICK_BIT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .clk_en_o    (clk_en_o),
    .busy        (kick_busy),
    .frame_last  (frame_last),
    .active_code (active_code),
    .pending_code(pending_code)
);

// File: tb/frac_rate_ctl_tb.sv
module frac_rate_ctl_tb;

    localparam logic [11:0] FREQ_A = 12'h0E0;
    localparam logic [11:0] KICK_A = 12'h004;
    localparam logic [11:0] SPARE_A = 12'h008;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        en;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    // reference model state
    int m_pend  = 0;
    int m_act   = 0;
    int m_state = 0;   // 0 idle, 1 waiting for boundary, 2 applied
    int m_pos   = 0;

    always #2 clk = ~clk;

    frac_rate_ctl u_dut (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (sel),
        .bus_wr   (wr),
        .bus_addr (addr),
        .bus_wdata(wdata),
        .bus_rdata(rdata),
        .clk_en_o (en)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic model_en();
        int m = 32 - m_act;
        return ((m_pos + 1) * m) / 32 != (m_pos * m) / 32;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (a == FREQ_A) return 32'(m_pend) << 8;
        if (a == KICK_A) return (m_state != 0) ? 32'h8000_0000 : 32'h0;
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pend = 0; m_act = 0; m_state = 0; m_pos = 0;
        end else begin
            if (m_state == 2) m_state = 0;
            else if (m_state == 1 && m_pos == 31) begin
                m_act = m_pend; m_state = 2;
            end else if (m_state == 0 && sel && wr && addr == KICK_A && wdata[31])
                m_state = 1;
            if (sel && wr && addr == FREQ_A) m_pend = int'(wdata[12:8]);
            m_pos = (m_pos + 1) % 32;
        end
    end

    always @(negedge clk) begin
        if (!rst) check(en == model_en(), "R8 enable pattern", 32'(en), 32'(model_en()));
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            check(1'b0, "watchdog", 32'(cyc), 32'h0);
            summary();
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, input string tag, output logic [31:0] got);
        logic [31:0] exp;
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        exp = model_read(a);
        got = rdata;
        check(got == exp, tag, got, exp);
        sel = 1'b0;
    endtask

    task automatic wait_done(input int start_cyc);
        logic [31:0] v;
        for (int i = 0; i < 60; i++) begin
            bus_read(KICK_A, "R5 busy readback", v);
            if (!v[31]) break;
        end
        check((cyc - start_cyc) <= 35, "R9 commit latency", 32'(cyc - start_cyc), 32'd35);
    endtask

    task automatic commit();
        int c0;
        c0 = cyc;
        bus_write(KICK_A, 32'h8000_0000);
        wait_done(c0);
    endtask

    task automatic count_frame(input int exp, input string tag);
        int n = 0;
        while (m_pos != 0) @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            n += int'(en);
            @(negedge clk);
        end
        check(n == exp, tag, 32'(n), 32'(exp));
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(FREQ_A, "R1 freq reset", v);
        bus_read(KICK_A, "R1 kick reset", v);
        count_frame(32, "R1 full rate after reset");

        // R2 pending only, other bits masked
        bus_write(FREQ_A, 32'hFFFF_ECFF);
        bus_read(FREQ_A, "R2 pending readback", v);
        check(v == 32'h0000_0C00, "R2 field placement", v, 32'h0000_0C00);
        count_frame(32, "R2 rate unchanged before commit");

        // R3 busy set, R4 applied at boundary
        bus_write(KICK_A, 32'h8000_0000);
        bus_read(KICK_A, "R3 busy set", v);
        check(v[31] == 1'b1, "R3 busy bit", v, 32'h8000_0000);
        wait_done(cyc - 2);
        count_frame(20, "R4 new rate 20/32");

        // R7 extremes
        bus_write(FREQ_A, 32'd31 << 8);
        commit();
        count_frame(1, "R7 code 31");
        bus_write(FREQ_A, 32'd0);
        commit();
        count_frame(32, "R7 code 0");
        bus_write(FREQ_A, 32'd17 << 8);
        commit();
        count_frame(15, "R8 code 17");

        // R6 repeated commit and zero write while busy
        bus_write(FREQ_A, 32'd5 << 8);
        bus_write(KICK_A, 32'h8000_0000);
        bus_write(KICK_A, 32'h8000_0000);
        bus_write(KICK_A, 32'h0);
        bus_read(KICK_A, "R6 zero write keeps busy", v);
        wait_done(cyc - 8);
        count_frame(27, "R6 rate after commit");
        bus_write(FREQ_A, 32'd9 << 8);
        count_frame(27, "R6 no commit no change");
        bus_write(KICK_A, 32'h0);
        bus_read(KICK_A, "R6 zero write idle", v);
        count_frame(27, "R6 zero write no apply");

        // R10 unmapped offsets
        bus_write(SPARE_A, 32'hFFFF_FFFF);
        bus_read(SPARE_A, "R10 unmapped read", v);
        bus_read(FREQ_A, "R10 pending untouched", v);
        bus_read(KICK_A, "R10 busy untouched", v);
        count_frame(27, "R10 rate untouched");

        // R4 pending rewritten while armed
        bus_write(FREQ_A, 32'd3 << 8);
        bus_write(KICK_A, 32'h8000_0000);
        bus_write(FREQ_A, 32'd7 << 8);
        wait_done(cyc - 4);
        count_frame(25, "R4 latest pending applied");

        repeat (3) @(negedge clk);
        summary();
    end

endmodule